// File: doc/BRIEF.md
# Asynchronous byte-wide SRAM strobe sequencer

This block sits between a synchronous host and an external static RAM that is 524,288 bytes deep and one byte wide. The host hands it a single-beat read or write request. The block converts that request into a timed sequence on the memory's active-low chip-select, output-enable and write-enable pins. It also drives the address bus and a split data bus: an outgoing byte, an output-enable flag for the pad driver, and an incoming byte.

Each window is a whole number of clock cycles. The window lengths come from nanosecond-style timing parameters (given in picoseconds) and the clock period. Each value is rounded up and is never less than one cycle. A write starts with chip-select and write-enable falling together and ends with write-enable rising while chip-select is still low. Chip-select is then kept low for a data-hold window. A recovery window with every strobe high follows every access.

The request side is a valid/ready interface. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only when the block is idle. The host must hold the request and its fields steady until it is taken. Read data returns on a one-cycle `rsp_valid` pulse, which has no back-pressure.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request taken with `req_write`=0 drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles, starting in the cycle after acceptance. RD_CYC is the larger of the access time and the read cycle time, in clock cycles.
- R3: Read data is sampled from `mem_dq_in` on the clock edge that closes the read window. It is presented on `rsp_rdata` together with a `rsp_valid` pulse that lasts exactly one cycle, in the first cycle after the window.
- R4: A request taken with `req_write`=1 lowers `mem_ce_n` and `mem_we_n` in the same cycle, the one after acceptance. `mem_we_n` stays 0 for WP_CYC cycles, and `mem_oe_n` stays 1 for the whole write.
- R5: A write is ended by `mem_we_n` rising while `mem_ce_n` is still 0. `mem_ce_n` then stays 0 for DH_CYC more cycles. `mem_dq_oe` is 1, with `mem_dq_out` equal to the accepted write byte, from the cycle `mem_we_n` falls through the last hold cycle, and only then.
- R6: Whenever `mem_ce_n` is 0, `mem_addr` equals the address of the request being served and does not change.
- R7: Every access is followed by REC_CYC cycles with all three strobes at 1 and `mem_dq_oe` at 0. `req_ready` is 0 from the cycle after acceptance through the last recovery cycle.
- R8: A request offered while `req_ready` is 0 is not taken. A held request is taken exactly once, and requests are served in the order offered.
- R9: Window lengths are ceil(time/CLK_PS) with a minimum of 1. WP_CYC is also raised so that WP_CYC+DH_CYC covers the write cycle time. With the defaults (10 ns clock, 70/70/55/70/0/5 ns) this gives RD_CYC=7, WP_CYC=6, DH_CYC=1 and REC_CYC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Byte driven toward memory |
| mem_dq_oe | output | 1 | Pad driver enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Byte read from the memory data pins |

## Verification
Several pin rules are checked on every cycle by properties:
- output-enable never overlaps write-enable;
- write-enable is low only inside chip-select;
- a write always ends with write-enable rising while chip-select is low;
- the address holds still while chip-select is low;
- the pad driver is on only while chip-select is low and output-enable is high;
- an idle block holds every strobe high;
- the response pulse lasts one cycle.

The exact window lengths, the recovery gaps, the edge on which read data is sampled, and the value returned need the bench's scenarios. In those scenarios, a memory model supplies data only once a read has been active for the full access time. The bench compares every pin against a per-cycle model of the expected waveform.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RECOV  = 3'd4
  } seq_state_e;

  // Whole cycles covering t_ps, never fewer than one.
  function automatic int unsigned to_cycles(input int unsigned t_ps,
                                            input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_strobe_pkg::*;
#(
  parameter int unsigned RD_CYC  = 7,
  parameter int unsigned WP_CYC  = 6,
  parameter int unsigned DH_CYC  = 1,
  parameter int unsigned REC_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       ready,
  output logic       accept,
  output logic       last,
  output seq_state_e st,
  output seq_state_e st_nxt
);
  localparam int unsigned MAXC = max2(max2(RD_CYC, WP_CYC), max2(DH_CYC, REC_CYC));
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RD_L  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_L  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] DH_L  = CNT_W'(DH_CYC - 1);
  localparam logic [CNT_W-1:0] REC_L = CNT_W'(REC_CYC - 1);

  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign ready  = (st == ST_IDLE);
  assign accept = ready && req_valid;
  assign last   = (cnt == '0);

  always_comb begin
    st_nxt  = st;
    cnt_nxt = last ? cnt : cnt - 1'b1;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        st_nxt  = req_write ? ST_WPULSE : ST_READ;
        cnt_nxt = req_write ? WP_L : RD_L;
      end
      ST_READ:   if (last) begin st_nxt = ST_RECOV; cnt_nxt = REC_L; end
      ST_WPULSE: if (last) begin st_nxt = ST_WHOLD; cnt_nxt = DH_L;  end
      ST_WHOLD:  if (last) begin st_nxt = ST_RECOV; cnt_nxt = REC_L; end
      ST_RECOV:  if (last) begin st_nxt = ST_IDLE;  cnt_nxt = '0;    end
      default:   begin st_nxt = ST_IDLE; cnt_nxt = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  seq_state_e        st_nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  logic sel_nxt, wr_nxt;

  assign wr_nxt  = (st_nxt == ST_WPULSE) || (st_nxt == ST_WHOLD);
  assign sel_nxt = wr_nxt || (st_nxt == ST_READ);

  // Strobes come straight from flops so the pins never glitch on state decode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= !sel_nxt;
      mem_oe_n  <= !(st_nxt == ST_READ);
      mem_we_n  <= !(st_nxt == ST_WPULSE);
      mem_dq_oe <= wr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end
endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture
  import sram_strobe_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        st,
  input  logic              last,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic take;
  assign take = (st == ST_READ) && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_rdata <= mem_dq_in;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_RC_PS  = 70000,
  parameter int unsigned T_ACC_PS = 70000,
  parameter int unsigned T_WP_PS  = 55000,
  parameter int unsigned T_WC_PS  = 70000,
  parameter int unsigned T_DH_PS  = 0,
  parameter int unsigned T_WR_PS  = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned RD_CYC  = max2(to_cycles(T_ACC_PS, CLK_PS), to_cycles(T_RC_PS, CLK_PS));
  localparam int unsigned DH_CYC  = to_cycles(T_DH_PS, CLK_PS);
  localparam int unsigned WC_CYC  = to_cycles(T_WC_PS, CLK_PS);
  localparam int unsigned WP_MIN  = to_cycles(T_WP_PS, CLK_PS);
  localparam int unsigned WP_CYC  = (WC_CYC > WP_MIN + DH_CYC) ? (WC_CYC - DH_CYC) : WP_MIN;
  localparam int unsigned REC_CYC = to_cycles(T_WR_PS, CLK_PS);

  seq_state_e st, st_nxt;
  logic       accept, last;

  sram_seq_fsm #(
    .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .DH_CYC(DH_CYC), .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .ready(req_ready), .accept(accept), .last(last), .st(st), .st_nxt(st_nxt)
  );

  sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .st_nxt(st_nxt),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  sram_read_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .st(st), .last(last), .mem_dq_in(mem_dq_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int unsigned ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);
  // R2
  read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R4
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R4
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  // R5
  we_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

  // R5
  dq_drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_strobe_ctrl.sv
module tb_sram_strobe_ctrl;
  localparam int CLK_NS = 10;
  localparam int AW = 19;
  localparam int DW = 8;
  // Window lengths worked out from the timing figures (ns) for a 10 ns clock.
  localparam int RD_CYC  = 7;  // ceil(70/10)
  localparam int WP_CYC  = 6;  // ceil(55/10), 6+1 covers 70 ns write cycle
  localparam int DH_CYC  = 1;  // 0 ns rounds up to one cycle
  localparam int REC_CYC = 1;  // ceil(5/10)

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] mem_dq_in = 8'hEE;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out;
  logic [AW-1:0] mem_addr;

  always #(CLK_NS/2) clk = ~clk;

  sram_strobe_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Stimulus list: kind 0 read, 1 write, 2 one idle gap.
  int            s_kind[$];
  logic [AW-1:0] s_addr[$];
  logic [DW-1:0] s_data[$];

  task automatic push(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    s_kind.push_back(k); s_addr.push_back(a); s_data.push_back(d);
  endtask

  // Reference model state.
  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] pin_mem [int];
  bit            m_busy = 0;
  int            m_kind = 0, m_age = 0, n_taken = 0, n_offered_req = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0;
  logic [DW-1:0] m_rexp = '0;
  bit            gap_now = 0;

  function automatic logic [DW-1:0] rd_ref(input logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  // Model advance on each edge; acceptance follows R8 (valid and idle).
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_age = 0;
    end else if (m_busy) begin
      m_age++;
      if ((m_kind == 0 && m_age == RD_CYC + REC_CYC) ||
          (m_kind == 1 && m_age == WP_CYC + DH_CYC + REC_CYC)) m_busy = 0;
    end else if (req_valid) begin
      m_busy = 1; m_age = 0; m_kind = req_write ? 1 : 0;
      m_addr = req_addr; m_data = req_wdata; n_taken++;
      if (req_write) ref_mem[int'(req_addr)] = req_wdata;
      else m_rexp = rd_ref(req_addr);
      void'(s_kind.pop_front()); void'(s_addr.pop_front()); void'(s_data.pop_front());
    end
  end

  int  rd_age = 0, we_low = 0;
  bit  prev_we = 1;

  task automatic compare_cycle();
    bit e_ce, e_oe, e_we, e_dq, e_rv;
    e_ce = 1; e_oe = 1; e_we = 1; e_dq = 0; e_rv = 0;
    if (m_busy) begin
      if (m_kind == 0) begin
        if (m_age < RD_CYC) begin e_ce = 0; e_oe = 0; end
        e_rv = (m_age == RD_CYC);
      end else begin
        if (m_age < WP_CYC) begin e_ce = 0; e_we = 0; e_dq = 1; end
        else if (m_age < WP_CYC + DH_CYC) begin e_ce = 0; e_dq = 1; end
      end
    end
    chk(m_kind ? "R4" : "R2", "mem_ce_n", mem_ce_n, e_ce);
    chk(m_kind ? "R4" : "R2", "mem_oe_n", mem_oe_n, e_oe);
    chk(m_kind ? "R5" : "R2", "mem_we_n", mem_we_n, e_we);
    chk("R5", "mem_dq_oe", mem_dq_oe, e_dq);
    chk("R7", "req_ready", req_ready, !m_busy);
    chk("R3", "rsp_valid", rsp_valid, e_rv);
    if (!e_ce) chk("R6", "mem_addr", mem_addr, m_addr);
    if (e_dq)  chk("R5", "mem_dq_out", mem_dq_out, m_data);
    if (e_rv)  chk("R3", "rsp_rdata", rsp_rdata, m_rexp);
  endtask

  // Pin-level memory: commits on write-enable rising, answers a read only once
  // the read strobes have been active for the full access time.
  task automatic memory_pins();
    if (!mem_we_n) we_low++;
    if (!prev_we && mem_we_n && !mem_ce_n) begin
      pin_mem[int'(mem_addr)] = mem_dq_out;
      // R9 measured write pulse length from the derived timing
      chk("R9", "write pulse cycles", we_low, WP_CYC);
      we_low = 0;
    end
    prev_we = mem_we_n;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age++; else rd_age = 0;
    if (rd_age >= RD_CYC)
      mem_dq_in = pin_mem.exists(int'(mem_addr)) ? pin_mem[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'hEE;
  endtask

  task automatic drive_next();
    if (gap_now) begin gap_now = 0; req_valid = 0; return; end
    if (s_kind.size() != 0 && s_kind[0] == 2 && !m_busy) begin
      void'(s_kind.pop_front()); void'(s_addr.pop_front()); void'(s_data.pop_front());
      req_valid = 0; return;
    end
    if (s_kind.size() != 0 && s_kind[0] != 2) begin
      req_valid = 1; req_write = (s_kind[0] == 1);
      req_addr = s_addr[0]; req_wdata = s_data[0];
    end else req_valid = 0;
  endtask

  initial begin : main
    int cyc;
    push(1, 19'h00005, 8'h3C);
    push(0, 19'h00005, 8'h00);
    push(1, 19'h7FFFF, 8'hA5);
    push(0, 19'h7FFFF, 8'h00);
    push(1, 19'h12345, 8'h11);
    push(1, 19'h00000, 8'hFF);
    push(2, 19'h0, 8'h0);
    push(0, 19'h12345, 8'h00);
    push(0, 19'h00000, 8'h00);
    push(0, 19'h2AAAA, 8'h00);
    push(1, 19'h12345, 8'h5A);
    push(0, 19'h12345, 8'h00);
    n_offered_req = 11;

    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset ce_n", mem_ce_n, 1);
      chk("R1", "reset oe_n", mem_oe_n, 1);
      chk("R1", "reset we_n", mem_we_n, 1);
      chk("R1", "reset dq_oe", mem_dq_oe, 0);
      chk("R1", "reset rsp_valid", rsp_valid, 0);
    end
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      compare_cycle();
      memory_pins();
      drive_next();
      if (s_kind.size() == 0 && !m_busy && !req_valid) break;
      if (cyc > 5000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
        break;
      end
    end
    repeat (3) begin @(negedge clk); compare_cycle(); end
    // R8 every request taken once and in order
    chk("R8", "requests taken", n_taken, n_offered_req);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule